// File: doc/BRIEF.md
# External Memory Bus Timing Sequencer

This block runs single accesses on an external parallel memory bus. An internal master offers a request with direction, address and write data. The block accepts it when idle and steps through an address setup phase, a strobe phase and an address hold phase. It then raises a one-cycle completion pulse. For reads, that pulse comes with the data captured from the bus.

The length of each phase comes from one 8-bit timing register, written over a small internal register port. Setup and hold are programmable from zero to three clocks; a zero-length phase takes no clock at all. The strobe lasts from one to sixteen clocks, and the same value serves reads and writes. The register comes out of reset at its slowest setting. Its value is copied when an access starts, so a write to the register changes only later accesses.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset the timing register reads 0xFF, `req_ready` is 1, `bus_rd_n` and `bus_wr_n` are 1, and `bus_oe`, `bus_active` and `done` are 0.
- R2: The timing register answers only at register address 0x84 and reads back on `reg_rdata`. Bits [7:6] are the setup code, bits [5:2] the strobe code and bits [1:0] the hold code. A write to any other address leaves it unchanged.
- R3: The address phase before the strobe lasts exactly the setup code in clocks (0 to 3). `bus_active` is high and both strobes are high during that phase. With code 0 the strobe begins in the first active cycle.
- R4: The strobe (`bus_rd_n` low for reads, `bus_wr_n` low for writes) lasts the strobe code plus one clocks, for either direction.
- R5: After the strobe, `bus_active` stays high with both strobes high for exactly the hold code in clocks (0 to 3).
- R6: A write holds `bus_oe` high and drives the request's write data on `bus_dout` in every active cycle. A read keeps `bus_oe` low. The two strobes are never low together.
- R7: A read returns on `rd_data` the value of `bus_din` sampled at the clock edge that ends the last strobe cycle.
- R8: `done` is high for one clock, in the first cycle after the final active cycle. `req_ready` is high only while idle. A request offered while busy is dropped and starts no access.
- R9: A timing-register write made during an access does not change that access. It applies from the next accepted request onward.
- R10: `bus_addr` equals the request address and stays constant in every active cycle of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Current timing register value |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read data captured at end of strobe |
| bus_addr | output | ADDR_W | External address bus |
| bus_dout | output | DATA_W | External data bus, outgoing |
| bus_oe | output | 1 | Output enable for `bus_dout` |
| bus_active | output | 1 | Address valid (setup, strobe or hold) |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_din | input | DATA_W | External data bus, incoming |

## Verification
Accesses are run under several timing settings: the reset setting (3/16/3), all-zero (0/1/0), and mixed settings such as 1/6/2, 2/4/0 and 0/16/3. These separate an off-by-one in the strobe code from a miscount in setup or hold. They also show whether a zero-length phase is truly skipped. The bench model drives `bus_din` with a value that changes every strobe cycle, so read data taken one clock early or late is caught. Other runs write the register mid-access, offer requests while busy, write an unused register address, and issue requests back to back.

// File: rtl/ext_bus_seq_pkg.sv
`timescale 1ns/1ps
package ext_bus_seq_pkg;
  localparam int SU_W = 2;
  localparam int WD_W = 4;
  localparam int HO_W = 2;
  localparam int TREG_W = SU_W + WD_W + HO_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } phase_e;

  // Field order follows the register bit layout: setup high, hold low.
  typedef struct packed {
    logic [SU_W-1:0] setup;
    logic [WD_W-1:0] width;
    logic [HO_W-1:0] hold;
  } timing_t;
endpackage

// File: rtl/ebs_timing_reg.sv
`timescale 1ns/1ps
module ebs_timing_reg
  import ext_bus_seq_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter logic [REG_AW-1:0] TIMING_ADDR = 8'h84
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [TREG_W-1:0] wdata,
  output timing_t           timing_q
);
  logic hit;
  assign hit = wr_en && (addr == TIMING_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      timing_q <= '1;
    end else if (hit) begin
      timing_q <= timing_t'(wdata);
    end
  end
endmodule

// File: rtl/ebs_phase_fsm.sv
`timescale 1ns/1ps
module ebs_phase_fsm
  import ext_bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  timing_t t_live,
  output phase_e  state_q,
  output phase_e  nxt_state,
  output logic    last_strobe,
  output logic    leave
);
  localparam int CNT_W = (WD_W > SU_W) ? ((WD_W > HO_W) ? WD_W : HO_W)
                                       : ((SU_W > HO_W) ? SU_W : HO_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WD_W-1:0]  width_q, width_d;
  logic [HO_W-1:0]  hold_q, hold_d;

  always_comb begin
    nxt_state = state_q;
    cnt_d     = cnt_q;
    width_d   = width_q;
    hold_d    = hold_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          width_d = t_live.width;
          hold_d  = t_live.hold;
          if (t_live.setup != '0) begin
            nxt_state = ST_SETUP;
            cnt_d     = CNT_W'(t_live.setup) - CNT_W'(1);
          end else begin
            nxt_state = ST_STROBE;
            cnt_d     = CNT_W'(t_live.width);
          end
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          nxt_state = ST_STROBE;
          cnt_d     = CNT_W'(width_q);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_STROBE: begin
        if (cnt_q == '0) begin
          if (hold_q != '0) begin
            nxt_state = ST_HOLD;
            cnt_d     = CNT_W'(hold_q) - CNT_W'(1);
          end else begin
            nxt_state = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_HOLD: begin
        if (cnt_q == '0) begin
          nxt_state = ST_IDLE;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  assign last_strobe = (state_q == ST_STROBE) && (cnt_q == '0);
  assign leave       = (state_q != ST_IDLE) && (nxt_state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      width_q <= '1;
      hold_q  <= '1;
    end else begin
      state_q <= nxt_state;
      cnt_q   <= cnt_d;
      width_q <= width_d;
      hold_q  <= hold_d;
    end
  end
endmodule

// File: rtl/ebs_bus_drive.sv
`timescale 1ns/1ps
module ebs_bus_drive
  import ext_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  phase_e            nxt_state,
  input  logic              last_strobe,
  input  logic              leave,
  input  logic [DATA_W-1:0] bus_din,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              bus_active,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);
  logic wr_q;
  logic wr_dir;
  logic nxt_busy;
  logic nxt_strobe;

  assign wr_dir     = start ? req_write : wr_q;
  assign nxt_busy   = (nxt_state != ST_IDLE);
  assign nxt_strobe = (nxt_state == ST_STROBE);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q       <= 1'b0;
      req_ready  <= 1'b1;
      done       <= 1'b0;
      rd_data    <= '0;
      bus_addr   <= '0;
      bus_dout   <= '0;
      bus_oe     <= 1'b0;
      bus_active <= 1'b0;
      bus_rd_n   <= 1'b1;
      bus_wr_n   <= 1'b1;
    end else begin
      if (start) begin
        wr_q     <= req_write;
        bus_addr <= req_addr;
        bus_dout <= req_wdata;
      end
      if (last_strobe && !wr_q) begin
        rd_data <= bus_din;
      end
      req_ready  <= !nxt_busy;
      done       <= leave;
      bus_active <= nxt_busy;
      bus_oe     <= nxt_busy && wr_dir;
      bus_rd_n   <= !(nxt_strobe && !wr_dir);
      bus_wr_n   <= !(nxt_strobe && wr_dir);
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
`timescale 1ns/1ps
module ext_bus_seq
  import ext_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int REG_AW = 8,
  parameter logic [REG_AW-1:0] TIMING_ADDR = 8'h84
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [TREG_W-1:0] reg_wdata,
  output logic [TREG_W-1:0] reg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_oe,
  output logic              bus_active,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  input  logic [DATA_W-1:0] bus_din
);
  timing_t timing_q;
  phase_e  state_q, nxt_state;
  logic    last_strobe, leave, start;

  assign start     = req_valid && req_ready;
  assign reg_rdata = timing_q;

  ebs_timing_reg #(.REG_AW(REG_AW), .TIMING_ADDR(TIMING_ADDR)) u_treg (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .timing_q (timing_q)
  );

  ebs_phase_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .t_live      (timing_q),
    .state_q     (state_q),
    .nxt_state   (nxt_state),
    .last_strobe (last_strobe),
    .leave       (leave)
  );

  ebs_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .nxt_state   (nxt_state),
    .last_strobe (last_strobe),
    .leave       (leave),
    .bus_din     (bus_din),
    .req_ready   (req_ready),
    .done        (done),
    .rd_data     (rd_data),
    .bus_addr    (bus_addr),
    .bus_dout    (bus_dout),
    .bus_oe      (bus_oe),
    .bus_active  (bus_active),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n)
  );
endmodule

// File: rtl/ebs_checker.sv
`timescale 1ns/1ps
module ebs_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_oe,
  input logic              bus_active,
  input logic              bus_rd_n,
  input logic              bus_wr_n
);
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));

  p_wr_oe_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> bus_oe);

  p_rd_no_oe_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_oe);

  p_strobe_in_access_r3: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_wr_n) |-> bus_active);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_access_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(bus_active) && !bus_active));

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && bus_active));

  p_addr_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_active && $past(bus_active)) |-> $stable(bus_addr));
endmodule

bind ext_bus_seq ebs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .done       (done),
  .bus_addr   (bus_addr),
  .bus_oe     (bus_oe),
  .bus_active (bus_active),
  .bus_rd_n   (bus_rd_n),
  .bus_wr_n   (bus_wr_n)
);

// File: tb/ext_bus_seq_test.sv
`timescale 1ns/1ps
module ext_bus_seq_test;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              reg_wr_en = 1'b0;
  logic [7:0]        reg_addr = '0;
  logic [7:0]        reg_wdata = '0;
  logic [7:0]        reg_rdata;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              done;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_dout;
  logic              bus_oe, bus_active, bus_rd_n, bus_wr_n;
  logic [DATA_W-1:0] bus_din = '0;

  ext_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .bus_active(bus_active), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_din(bus_din)
  );

  typedef struct {
    bit                wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    int                su;
    int                wd;
    int                ho;
  } exp_t;

  exp_t       q[$];
  int         checks = 0;
  int         errors = 0;
  int         n_done = 0;
  logic [7:0] shadow = 8'hFF;
  bit         finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- monitor / scoreboard ----------------
  bit         in_acc = 0;
  bit         seen_str = 0;
  bit         wr_seen = 0;
  bit         prev_done = 0;
  int         su_c, st_c, ho_c, oe_c, addr_bad, dout_bad, ready_bad;
  logic [ADDR_W-1:0] a0;
  exp_t       cur;

  always @(negedge clk) begin
    if (rst) begin
      in_acc = 0;
      prev_done = 0;
    end else begin
      if (bus_active) begin
        if (!in_acc) begin
          in_acc = 1; seen_str = 0; wr_seen = 0;
          su_c = 0; st_c = 0; ho_c = 0; oe_c = 0;
          addr_bad = 0; dout_bad = 0; ready_bad = 0;
          a0 = bus_addr;
          if (q.size() > 0) cur = q[0];
          else chk(0, "R8", "access started without request", 1, 0);
        end
        if (!bus_rd_n || !bus_wr_n) begin
          if (!bus_rd_n) bus_din = a0[7:0] + 8'(st_c);
          else wr_seen = 1;
          st_c++;
          seen_str = 1;
        end else if (!seen_str) su_c++;
        else ho_c++;
        if (bus_addr != a0) addr_bad++;
        if (bus_oe) begin
          oe_c++;
          if (bus_dout != cur.data) dout_bad++;
        end
        if (req_ready) ready_bad++;
      end
      if (done) begin
        chk(!prev_done, "R8", "done longer than one cycle", 1, 0);
        if (q.size() == 0) begin
          chk(0, "R8", "done without pending access", 1, 0);
        end else begin
          cur = q.pop_front();
          chk(a0 == cur.addr && addr_bad == 0, "R10", "bus address", int'(a0), int'(cur.addr));
          chk(su_c == cur.su, "R3", "setup cycles", su_c, cur.su);
          chk(st_c == cur.wd, "R4", "strobe cycles", st_c, cur.wd);
          chk(ho_c == cur.ho, "R5", "hold cycles", ho_c, cur.ho);
          chk(wr_seen == cur.wr, "R6", "strobe direction", int'(wr_seen), int'(cur.wr));
          chk(oe_c == (cur.wr ? su_c + st_c + ho_c : 0), "R6", "oe cycles",
              oe_c, cur.wr ? su_c + st_c + ho_c : 0);
          chk(dout_bad == 0, "R6", "write data mismatches", dout_bad, 0);
          chk(ready_bad == 0, "R8", "ready high while busy", ready_bad, 0);
          if (!cur.wr) begin
            logic [7:0] e;
            e = cur.addr[7:0] + 8'(cur.wd - 1);
            chk(rd_data == e, "R7", "read data", int'(rd_data), int'(e));
          end
        end
        n_done++;
        in_acc = 0;
      end
      prev_done = done;
    end
  end

  // ---------------- driver ----------------
  task automatic reg_write(logic [7:0] a, logic [7:0] v);
    reg_wr_en = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr_en = 0;
    if (a == 8'h84) shadow = v;
  endtask

  task automatic issue(bit wr, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    exp_t e;
    while (!req_ready) @(negedge clk);
    e.wr = wr; e.addr = a; e.data = d;
    e.su = int'(shadow[7:6]);
    e.wd = int'(shadow[5:2]) + 1;
    e.ho = int'(shadow[1:0]);
    q.push_back(e);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_pair(logic [7:0] t, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    reg_write(8'h84, t);
    chk(reg_rdata == t, "R2", "register readback", int'(reg_rdata), int'(t));
    issue(1, a, d);
    drain();
    issue(0, a + 16'h0101, d);
    drain();
  endtask

  initial begin
    int base_done;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(reg_rdata == 8'hFF, "R1", "reset register", int'(reg_rdata), 255);
    chk(req_ready == 1'b1, "R1", "reset ready", int'(req_ready), 1);
    chk(bus_rd_n && bus_wr_n, "R1", "reset strobes high", int'({bus_rd_n, bus_wr_n}), 3);
    chk(!bus_oe && !bus_active && !done, "R1", "reset oe/active/done",
        int'({bus_oe, bus_active, done}), 0);

    // default slowest timing, read then write
    issue(0, 16'h1234, 8'h00);
    drain();
    issue(1, 16'h2468, 8'hA5);
    drain();

    // various timing patterns (R3 R4 R5)
    run_pair(8'h00, 16'h0310, 8'h3C);   // 0/1/0
    run_pair(8'h56, 16'h4422, 8'h96);   // 1/6/2
    run_pair(8'h8C, 16'h5530, 8'h11);   // 2/4/0
    run_pair(8'h3F, 16'h6640, 8'hE7);   // 0/16/3
    run_pair(8'hC1, 16'h7750, 8'h42);   // 3/1/1

    // R2: other address ignored
    reg_write(8'h85, 8'h00);
    chk(reg_rdata == 8'hC1, "R2", "write to other address ignored", int'(reg_rdata), 193);
    reg_write(8'h04, 8'h12);
    chk(reg_rdata == 8'hC1, "R2", "write to 0x04 ignored", int'(reg_rdata), 193);

    // R9: register write during access
    reg_write(8'h84, 8'h56);
    issue(1, 16'h8860, 8'h5A);
    @(negedge clk);
    reg_write(8'h84, 8'h00);
    chk(bus_active == 1'b1, "R9", "register written while busy", int'(bus_active), 1);
    drain();
    issue(0, 16'h9970, 8'h00);
    drain();

    // R8: request while busy is dropped
    reg_write(8'h84, 8'hFF);
    base_done = n_done;
    issue(0, 16'hA080, 8'h00);
    repeat (3) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'hBEEF; req_wdata = 8'h77;
    for (int i = 0; i < 3; i++) begin
      chk(req_ready == 1'b0, "R8", "ready while busy", int'(req_ready), 0);
      @(negedge clk);
    end
    req_valid = 0;
    drain();
    repeat (4) @(negedge clk);
    chk(!bus_active, "R8", "no access from dropped request", int'(bus_active), 0);
    chk(n_done == base_done + 1, "R8", "done count", n_done - base_done, 1);

    // back-to-back requests at zero setup/hold
    reg_write(8'h84, 8'h08);            // 0/3/0
    issue(0, 16'hB190, 8'h00);
    issue(1, 16'hC2A0, 8'h6E);
    issue(0, 16'hD3B0, 8'h00);
    drain();

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule